// File: doc/BRIEF.md
# Quantized Output Skew Control

This block takes one divided clock phase, shared by several output channels that all use the same divide setting, and produces a separately delayed copy of it for each channel. Delay is measured in fine ticks. One fine tick is one thirty-second of the fast source period and is modelled as one cycle of the block's timing clock `clk`. The output period is therefore 32 times the divide ratio in fine ticks, and a channel can be placed anywhere in that period. Its phase step is 360 / (32 x ratio) degrees. For example, a ratio of 28 gives about 0.402 degrees per step.

The common reference arrives as a one-tick `ref_pulse` at every output period boundary. If no pulse arrives, an internal phase counter keeps running at the latched period. At each boundary every channel takes in its skew count, reduced modulo the period, and its invert bit. Each channel also has an enable. A disabled channel sits at logic 0, and enable changes are held back until the channel's level is low, so no pulse is ever cut short or started late.

Top module: `skew_fanout`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, every `clk_out` bit is 0.
- R2: The edge of `clk` that samples `ref_pulse` high is a period boundary. At that edge the period becomes 32 x `div_ratio` fine ticks, with a ratio of 0 taken as 1. Between pulses the phase counter wraps at that period on its own.
- R3: For an enabled, non-inverted channel with latched skew s, `clk_out` goes high at the edge that comes s ticks after the boundary edge. It stays high for half the period and low for the other half.
- R4: A skew count at or above the period acts as that count modulo the period (the full 12-bit count is used).
- R5: Skew count and invert bit are taken only at a period boundary. A change between boundaries has no effect until the next boundary.
- R6: With its invert bit latched as 1, a channel's level is the complement of its non-inverted level.
- R7: A channel whose enable has been 0 while its output was low stays at logic 0.
- R8: An enable or disable takes effect only at an edge where the channel's ungated level is low. Disabling during a high phase lets that high phase run its full length. Enabling during a high phase waits for the next full high phase.
- R9: Channels are independent. Each follows only its own skew, invert and enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fine timing clock, one tick = 1/32 source period |
| rst | input | 1 | Synchronous active-high reset |
| ref_pulse | input | 1 | One-tick marker of the reference period boundary |
| div_ratio | input | RATIO_W | Common divide ratio (0 treated as 1) |
| skew_cnt | input | LANES*SKEW_W | Per-channel skew in fine ticks, channel i at bits [i*SKEW_W +: SKEW_W] |
| inv | input | LANES | Per-channel invert request |
| en | input | LANES | Per-channel enable request |
| clk_out | output | LANES | Skewed channel clocks |

## Verification
The hardest case to reach is an enable or disable that arrives while a channel's level is high, because only then does the held-back transition make any difference. The stimulus counts ticks from a boundary pulse and flips the enables a few ticks into a known high phase. It does this for one channel being disabled and for another being enabled. Skew and invert are also changed in the middle of a period, so that a value taken too early would show up in the output before the next boundary.

// File: rtl/skew_pkg.sv
package skew_pkg;

    localparam int unsigned FINE_PER_SRC = 32;
    localparam int unsigned FINE_LOG2    = 5;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;

    typedef struct packed {
        logic inv;
        logic en;
    } lane_mode_t;

    function automatic int unsigned eff_period(int unsigned ratio);
        return ((ratio == 0) ? 1 : ratio) * FINE_PER_SRC;
    endfunction

    function automatic int unsigned wrap_skew(int unsigned s, int unsigned p);
        return s % p;
    endfunction

    function automatic lvl_e lane_level(int unsigned ph, int unsigned sk,
                                        int unsigned p, logic flip);
        int unsigned d;
        d = (ph >= sk) ? (ph - sk) : (ph + p - sk);
        return ((d < (p / 2)) != flip) ? LVL_HIGH : LVL_LOW;
    endfunction

endpackage

// File: rtl/skew_phase.sv
module skew_phase
    import skew_pkg::*;
#(
    parameter int RATIO_W = 6,
    parameter int PH_W    = RATIO_W + 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ref_pulse,
    input  logic [RATIO_W-1:0] div_ratio,
    output logic [PH_W-1:0]    phase_nx,
    output logic [PH_W-1:0]    period_nx,
    output logic [PH_W-1:0]    phase_q,
    output logic [PH_W-1:0]    period_q
);

    logic [PH_W:0] inc;

    always_comb begin
        inc = {1'b0, phase_q} + 1'b1;
        if (ref_pulse) begin
            period_nx = PH_W'(eff_period(32'(div_ratio)));
            phase_nx  = '0;
        end else begin
            period_nx = period_q;
            phase_nx  = (inc >= {1'b0, period_q}) ? '0 : inc[PH_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= '0;
            period_q <= PH_W'(FINE_PER_SRC);
        end else begin
            phase_q  <= phase_nx;
            period_q <= period_nx;
        end
    end

endmodule

// File: rtl/skew_lane.sv
module skew_lane
    import skew_pkg::*;
#(
    parameter int SKEW_W = 12,
    parameter int PH_W   = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boundary,
    input  logic [PH_W-1:0]   phase_nx,
    input  logic [PH_W-1:0]   period_nx,
    input  logic [SKEW_W-1:0] skew_in,
    input  logic              inv_in,
    input  logic              en_in,
    output logic              clk_out,
    output logic [PH_W-1:0]   skew_q
);

    logic [PH_W-1:0] skew_nx;
    logic            inv_nx;
    lane_mode_t      mode_q;
    lvl_e            lvl;

    always_comb begin
        if (boundary) begin
            skew_nx = PH_W'(wrap_skew(32'(skew_in), 32'(period_nx)));
            inv_nx  = inv_in;
        end else begin
            skew_nx = skew_q;
            inv_nx  = mode_q.inv;
        end
        lvl = lane_level(32'(phase_nx), 32'(skew_nx), 32'(period_nx), inv_nx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            skew_q  <= '0;
            mode_q  <= '0;
            clk_out <= 1'b0;
        end else begin
            skew_q     <= skew_nx;
            mode_q.inv <= inv_nx;
            if (lvl == LVL_LOW) begin
                mode_q.en <= en_in;
            end
            clk_out <= mode_q.en && (lvl == LVL_HIGH);
        end
    end

endmodule

// File: rtl/skew_fanout.sv
module skew_fanout
    import skew_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int SKEW_W  = 12,
    parameter int RATIO_W = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ref_pulse,
    input  logic [RATIO_W-1:0]      div_ratio,
    input  logic [LANES*SKEW_W-1:0] skew_cnt,
    input  logic [LANES-1:0]        inv,
    input  logic [LANES-1:0]        en,
    output logic [LANES-1:0]        clk_out
);

    localparam int PH_W = RATIO_W + FINE_LOG2;

    logic [PH_W-1:0]       phase_nx;
    logic [PH_W-1:0]       period_nx;
    logic [PH_W-1:0]       phase_q;
    logic [PH_W-1:0]       period_q;
    logic [LANES*PH_W-1:0] skew_act_all;

    skew_phase #(.RATIO_W(RATIO_W), .PH_W(PH_W)) i_phase (
        .clk       (clk),
        .rst       (rst),
        .ref_pulse (ref_pulse),
        .div_ratio (div_ratio),
        .phase_nx  (phase_nx),
        .period_nx (period_nx),
        .phase_q   (phase_q),
        .period_q  (period_q)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        skew_lane #(.SKEW_W(SKEW_W), .PH_W(PH_W)) i_lane (
            .clk       (clk),
            .rst       (rst),
            .boundary  (ref_pulse),
            .phase_nx  (phase_nx),
            .period_nx (period_nx),
            .skew_in   (skew_cnt[g*SKEW_W +: SKEW_W]),
            .inv_in    (inv[g]),
            .en_in     (en[g]),
            .clk_out   (clk_out[g]),
            .skew_q    (skew_act_all[g*PH_W +: PH_W])
        );
    end

endmodule

// File: rtl/skew_fanout_chk.sv
module skew_fanout_chk #(
    parameter int LANES = 4,
    parameter int PH_W  = 11
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  ref_pulse,
    input logic [PH_W-1:0]       phase_q,
    input logic [PH_W-1:0]       period_q,
    input logic [LANES*PH_W-1:0] skew_act_all,
    input logic [LANES-1:0]      en,
    input logic [LANES-1:0]      clk_out
);

    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R2: a boundary restarts the phase count
    a_r2_phase_restart: assert property (@(posedge clk) disable iff (rst)
        ref_pulse |=> (phase_q == '0));

    // R2: the free-running phase stays inside the latched period
    a_r2_phase_in_period: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (phase_q < period_q));

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        // R4: the latched skew is always reduced below the period
        a_r4_skew_wrapped: assert property (@(posedge clk) disable iff (rst)
            past_ok |-> (skew_act_all[g*PH_W +: PH_W] < period_q));

        // R7: low and disabled stays low
        a_r7_disabled_low: assert property (@(posedge clk) disable iff (rst)
            (past_ok && !$past(clk_out[g]) && !$past(en[g])) |-> !clk_out[g]);
    end

endmodule

bind skew_fanout skew_fanout_chk #(.LANES(LANES), .PH_W(PH_W)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .ref_pulse    (ref_pulse),
    .phase_q      (phase_q),
    .period_q     (period_q),
    .skew_act_all (skew_act_all),
    .en           (en),
    .clk_out      (clk_out)
);

// File: tb/test_skew_fanout.sv
module test_skew_fanout;

    localparam int LANES   = 3;
    localparam int SKEW_W  = 12;
    localparam int RATIO_W = 6;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    ref_pulse = 1'b0;
    logic [RATIO_W-1:0]      div_ratio = RATIO_W'(1);
    logic [LANES*SKEW_W-1:0] skew_cnt = '0;
    logic [LANES-1:0]        inv = '0;
    logic [LANES-1:0]        en = '0;
    logic [LANES-1:0]        clk_out;

    skew_fanout #(.LANES(LANES), .SKEW_W(SKEW_W), .RATIO_W(RATIO_W)) i_skew_fanout (
        .clk       (clk),
        .rst       (rst),
        .ref_pulse (ref_pulse),
        .div_ratio (div_ratio),
        .skew_cnt  (skew_cnt),
        .inv       (inv),
        .en        (en),
        .clk_out   (clk_out)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string cur_req = "R1";

    int m_per = 32;
    int m_t   = 0;
    int m_sk[LANES];
    bit m_inv[LANES];
    bit m_en[LANES];

    logic [LANES-1:0] exp_q[$];
    string            tag_q[$];

    initial begin
        for (int i = 0; i < LANES; i++) begin
            m_sk[i] = 0; m_inv[i] = 1'b0; m_en[i] = 1'b0;
        end
    end

    task automatic set_skew(int lane, int v);
        skew_cnt[lane*SKEW_W +: SKEW_W] = SKEW_W'(v);
    endtask

    // reference model: level from ticks elapsed since the boundary
    task automatic model_step();
        logic [LANES-1:0] e;
        if (ref_pulse) begin
            m_per = 32 * ((div_ratio == 0) ? 1 : int'(div_ratio));
            m_t   = 0;
            for (int i = 0; i < LANES; i++) begin
                m_sk[i]  = int'(skew_cnt[i*SKEW_W +: SKEW_W]) % m_per;
                m_inv[i] = inv[i];
            end
        end else begin
            m_t = (m_t + 1) % m_per;
        end
        for (int i = 0; i < LANES; i++) begin
            int d;
            bit lvl;
            d   = (((m_t - m_sk[i]) % m_per) + m_per) % m_per;
            lvl = (d < m_per / 2) ^ m_inv[i];
            if (!lvl) m_en[i] = en[i];
            e[i] = m_en[i] & lvl;
        end
        exp_q.push_back(e);
        tag_q.push_back(cur_req);
    endtask

    // driver: called at a negedge, returns at the next negedge
    task automatic tick(bit r);
        ref_pulse = r;
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic periods(int n);
        int p;
        p = 32 * ((div_ratio == 0) ? 1 : int'(div_ratio));
        for (int k = 0; k < n; k++) begin
            tick(1'b1);
            repeat (p - 1) tick(1'b0);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            logic [LANES-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (clk_out !== e) begin
                fails++;
                $display("FAIL %s: clk_out=%b expected %b", t, clk_out, e);
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs low in reset
        checks++;
        if (clk_out !== '0) begin
            fails++;
            $display("FAIL R1: clk_out=%b expected %b", clk_out, {LANES{1'b0}});
        end
        rst = 1'b0;
        cur_req = "R1";
        tick(1'b0);

        // R3 / R9: distinct skews, ratio 1
        cur_req = "R3";
        div_ratio = 1;
        set_skew(0, 0); set_skew(1, 5); set_skew(2, 31);
        en = '1;
        periods(3);

        // R3 / R9: ratio 3, full range of skews
        cur_req = "R9";
        div_ratio = 3;
        set_skew(0, 0); set_skew(1, 47); set_skew(2, 95);
        periods(2);

        // R4: counts beyond the period wrap
        cur_req = "R4";
        div_ratio = 1;
        set_skew(0, 40); set_skew(1, 100); set_skew(2, 4095);
        periods(2);

        // R5 / R6: change skew and invert mid-period
        cur_req = "R5";
        div_ratio = 2;
        set_skew(0, 3); set_skew(1, 10); set_skew(2, 60);
        periods(1);
        tick(1'b1);
        repeat (9) tick(1'b0);
        set_skew(0, 20);
        inv = 3'b010;
        repeat (54) tick(1'b0);
        cur_req = "R6";
        periods(2);

        // R7: channel 2 disabled
        cur_req = "R7";
        inv = '0;
        en = 3'b011;
        periods(2);

        // R8: enable/disable requests during a high phase
        cur_req = "R8";
        div_ratio = 1;
        set_skew(0, 0); set_skew(1, 8); set_skew(2, 0);
        periods(1);
        tick(1'b1);
        repeat (4) tick(1'b0);
        en[0] = 1'b0;
        en[2] = 1'b1;
        repeat (27) tick(1'b0);
        periods(2);

        // R2: free running between pulses, ratio 0 treated as 1
        cur_req = "R2";
        div_ratio = 2;
        en = '1;
        tick(1'b1);
        repeat (200) tick(1'b0);
        div_ratio = 0;
        set_skew(1, 33);
        periods(2);
        repeat (70) tick(1'b0);

        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule